// File: doc/BRIEF.md
# Write-completion status read encoder

This block sits on the read data path of a page-write nonvolatile memory. While the memory runs its own internal write cycle or chip-erase cycle, a normal read cannot return array contents. Instead, this block replaces the read data with two end-of-write indicators that host software polls.

The first is a polarity indicator on the top data bit. During a write it reads as the inverse of the top bit of the byte loaded last. The second is an alternating bit on the next bit down. It flips once per completed read access for as long as a write or erase cycle runs, and it reads 1 on the first access after a cycle starts.

Once a write finishes, only the polarity bit is trustworthy for a short settling window. The block returns the true top bit and holds every other bit low until the window expires. After that it passes the array data through unchanged. The data bus enable is high only while both active-low strobes are low.

Top module: `wstat_read_enc`

## Requirements
- R1: `dq_oe` is 1 only while `chip_sel_n` and `out_en_n` are both 0. Whenever `dq_oe` is 0, `dq_out` is 8'h00. Under reset with both strobes high, `dq_oe` is 0.
- R2: With no cycle in progress and the settling window over, a read returns `arr_rd` unchanged.
- R3: While `wr_busy` is 1, bit 7 of a read equals the inverse of bit 7 of `last_ld`. Array data has no effect on this bit.
- R4: While `wr_busy` or `er_busy` is 1, bit 6 of a read alternates. It reads 1 on the first access after a cycle starts. It advances only when a read access ends, that is, when either strobe rises while both were low at the previous clock edge. Holding a read open across several clock edges keeps the bit constant.
- R5: While `wr_busy` or `er_busy` is 1, bits 5..0 of a read are 0.
- R6: While `er_busy` is 1 and `wr_busy` is 0, bit 7 of a read is 0.
- R7: A rising edge of `wr_busy` or `er_busy` clears the alternating bit. This holds even when a read access ends in the same clock cycle, so the next read returns bit 6 = 1.
- R8: When `wr_busy` falls, reads return bit 7 of `arr_rd` with bits 6..0 at 0. This lasts from the fall until `SETTLE_CYCLES` rising clock edges after the first edge that sees `wr_busy` low.
- R9: After the settling window ends, reads return the full `arr_rd` byte (R2).
- R10: When `wr_busy` and `er_busy` are both 1, the write encoding (R3) applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low chip select strobe |
| out_en_n | input | 1 | Active-low output enable strobe |
| wr_busy | input | 1 | Internal write cycle in progress |
| er_busy | input | 1 | Internal chip-erase cycle in progress |
| last_ld | input | DATA_W | Last byte loaded into the page buffer |
| arr_rd | input | DATA_W | Array read data |
| dq_out | output | DATA_W | Data bus value |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Two events can land on the same clock edge: the end of a read access, which advances the alternating bit, and the start of a new write cycle, which clears it. The bench provokes the collision in one negedge step. It raises both strobes and `wr_busy` together while the alternating bit is 0, so the edge detects a cycle start and a read end at once. The next read must show bit 6 = 1. It would show 0 if the advance had beaten the clear.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

   typedef enum logic [1:0] {
      RDM_ARRAY  = 2'd0,
      RDM_WRITE  = 2'd1,
      RDM_ERASE  = 2'd2,
      RDM_SETTLE = 2'd3
   } rd_mode_e;

endpackage

// File: rtl/wstat_strobe_track.sv
module wstat_strobe_track (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel_n,
   input  logic out_en_n,
   output logic rd_now,
   output logic rd_end
);
   logic rd_q;

   assign rd_now = ~chip_sel_n & ~out_en_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rd_n_ok(rst_n)) rd_q <= 1'b0;
      else                 rd_q <= rd_now;
   end

   function automatic logic rd_n_ok(input logic r);
      return r;
   endfunction

   assign rd_end = rd_q & ~rd_now;

endmodule

// File: rtl/wstat_cycle_track.sv
module wstat_cycle_track #(
   parameter int SETTLE_CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_busy,
   input  logic er_busy,
   output logic cyc_start,
   output logic settling
);
   localparam int CW = (SETTLE_CYCLES > 0) ? $clog2(SETTLE_CYCLES + 1) : 1;

   logic wr_q;
   logic er_q;
   logic wr_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         er_q <= 1'b0;
      end else begin
         wr_q <= wr_busy;
         er_q <= er_busy;
      end
   end

   assign cyc_start = (wr_busy & ~wr_q) | (er_busy & ~er_q);
   assign wr_fall   = wr_q & ~wr_busy;

   generate
      if (SETTLE_CYCLES == 0) begin : g_no_settle
         assign settling = 1'b0;
      end else begin : g_settle
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (wr_busy)        cnt_q <= '0;
            else if (wr_fall)        cnt_q <= CW'(SETTLE_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
         end

         assign settling = ~wr_busy & (wr_fall | (cnt_q != '0));

         AST_SETTLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(SETTLE_CYCLES)); // R8
         AST_SETTLE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            wr_fall |=> (cnt_q == CW'(SETTLE_CYCLES)) || wr_busy); // R8
      end
   endgenerate

endmodule

// File: rtl/wstat_toggle_cell.sv
module wstat_toggle_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic tog_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog_q <= 1'b0;
      else if (clear)   tog_q <= 1'b0;
      else if (advance) tog_q <= ~tog_q;
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !tog_q); // R7
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> (tog_q != $past(tog_q))); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(tog_q)); // R4

endmodule

// File: rtl/wstat_out_mux.sv
module wstat_out_mux
   import wstat_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_mode_e          mode,
   input  logic              rd_now,
   input  logic              tog_q,
   input  logic [DATA_W-1:0] last_ld,
   input  logic [DATA_W-1:0] arr_rd,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   localparam logic [DATA_W-1:0] POLL_M   = DATA_W'(1) << POLL_BIT;
   localparam logic [DATA_W-1:0] TOGGLE_M = DATA_W'(1) << TOGGLE_BIT;
   localparam logic [DATA_W-1:0] STAT_M   = POLL_M | TOGGLE_M;

   logic              last_top;
   logic [DATA_W-1:0] tog_field;
   logic [DATA_W-1:0] sel_data;

   assign last_top  = |(last_ld & POLL_M);
   assign tog_field = tog_q ? '0 : TOGGLE_M;

   always_comb begin
      unique case (mode)
         RDM_WRITE:  sel_data = (last_top ? '0 : POLL_M) | tog_field;
         RDM_ERASE:  sel_data = tog_field;
         RDM_SETTLE: sel_data = arr_rd & POLL_M;
         default:    sel_data = arr_rd;
      endcase
   end

   assign dq_oe  = rd_now;
   assign dq_out = rd_now ? sel_data : '0;

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0)); // R1
   AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && mode == RDM_WRITE) |-> (|(dq_out & POLL_M)) != (|(last_ld & POLL_M))); // R3
   AST_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && (mode == RDM_WRITE || mode == RDM_ERASE)) |-> ((dq_out & ~STAT_M) == '0)); // R5
   AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && mode == RDM_ERASE) |-> ((dq_out & POLL_M) == '0)); // R6
   AST_SETTLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && mode == RDM_SETTLE) |-> ((dq_out & ~POLL_M) == '0)); // R8

endmodule

// File: rtl/wstat_read_enc.sv
module wstat_read_enc
   import wstat_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int POLL_BIT      = 7,
   parameter int TOGGLE_BIT    = 6,
   parameter int SETTLE_CYCLES = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_sel_n,
   input  logic              out_en_n,
   input  logic              wr_busy,
   input  logic              er_busy,
   input  logic [DATA_W-1:0] last_ld,
   input  logic [DATA_W-1:0] arr_rd,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("wstat_read_enc: DATA_W must be at least 2");
      end
      if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W || POLL_BIT < 0 || TOGGLE_BIT < 0) begin : g_bad_pos
         $error("wstat_read_enc: status bit position out of range");
      end
      if (POLL_BIT == TOGGLE_BIT) begin : g_bad_overlap
         $error("wstat_read_enc: status bits must differ");
      end
      if (SETTLE_CYCLES < 0) begin : g_bad_settle
         $error("wstat_read_enc: SETTLE_CYCLES must not be negative");
      end
   endgenerate

   logic     rd_now;
   logic     rd_end;
   logic     cyc_start;
   logic     settling;
   logic     tog_q;
   logic     in_cycle;
   rd_mode_e mode;

   wstat_strobe_track u_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_sel_n (chip_sel_n),
      .out_en_n   (out_en_n),
      .rd_now     (rd_now),
      .rd_end     (rd_end)
   );

   wstat_cycle_track #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_cycle (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_busy   (wr_busy),
      .er_busy   (er_busy),
      .cyc_start (cyc_start),
      .settling  (settling)
   );

   assign in_cycle = wr_busy | er_busy;

   wstat_toggle_cell u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cyc_start),
      .advance (rd_end & in_cycle),
      .tog_q   (tog_q)
   );

   always_comb begin
      if (wr_busy)       mode = RDM_WRITE;
      else if (er_busy)  mode = RDM_ERASE;
      else if (settling) mode = RDM_SETTLE;
      else               mode = RDM_ARRAY;
   end

   wstat_out_mux #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT)
   ) u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .rd_now  (rd_now),
      .tog_q   (tog_q),
      .last_ld (last_ld),
      .arr_rd  (arr_rd),
      .dq_out  (dq_out),
      .dq_oe   (dq_oe)
   );

   AST_OE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!chip_sel_n && !out_en_n)); // R1
   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && !in_cycle && !settling) |-> (dq_out == arr_rd)); // R2
   AST_WRITE_OVER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && er_busy) |-> (mode == RDM_WRITE)); // R10

endmodule

// File: tb/wstat_read_enc_tb.sv
module wstat_read_enc_tb_top;
   localparam int DW = 8;
   localparam int ST = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chip_sel_n = 1'b1;
   logic          out_en_n = 1'b1;
   logic          wr_busy = 1'b0;
   logic          er_busy = 1'b0;
   logic [DW-1:0] last_ld = '0;
   logic [DW-1:0] arr_rd = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wstat_read_enc #(.DATA_W(DW), .POLL_BIT(7), .TOGGLE_BIT(6), .SETTLE_CYCLES(ST)) dut_i (
      .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
      .wr_busy(wr_busy), .er_busy(er_busy), .last_ld(last_ld), .arr_rd(arr_rd),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic rd_access(output logic [DW-1:0] v);
      @(negedge clk);
      chip_sel_n = 1'b0;
      out_en_n   = 1'b0;
      @(negedge clk);
      #1;
      v = dq_out;
      chip_sel_n = 1'b1;
      out_en_n   = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] exp;

      // R1 reset state
      #5;
      chk("R1 reset", {dq_oe, dq_out}, {1'b0, 8'h00});
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 single strobe low never drives
      @(negedge clk);
      arr_rd = 8'hA7;
      chip_sel_n = 1'b0;
      #1 chk("R1 cs only", {dq_oe, dq_out}, {1'b0, 8'h00});
      @(negedge clk);
      chip_sel_n = 1'b1;
      out_en_n = 1'b0;
      #1 chk("R1 oe only", {dq_oe, dq_out}, {1'b0, 8'h00});
      out_en_n = 1'b1;

      // R2 idle sweep
      for (int i = 0; i < 256; i++) begin
         arr_rd = 8'(i);
         rd_access(v);
         chk("R2 idle read", {1'b0, v}, {1'b0, 8'(i)});
      end

      // R3 R5 R4 write sweep over every last byte value
      @(negedge clk);
      wr_busy = 1'b1;
      for (int i = 0; i < 256; i++) begin
         last_ld = 8'(i);
         arr_rd  = 8'(i) ^ 8'h5A;
         rd_access(v);
         exp = {~last_ld[7], ((i % 2) == 0) ? 1'b1 : 1'b0, 6'b0};
         chk("R3 R4 R5 write status", {1'b0, v}, {1'b0, exp});
      end

      // R4 long read: constant across edges; ends on chip select alone
      last_ld = 8'h80;
      @(negedge clk);
      chip_sel_n = 1'b0;
      out_en_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         #1 chk("R4 held read", {1'b0, dq_out}, {1'b0, 8'h40});
      end
      chip_sel_n = 1'b1;
      @(negedge clk);
      chip_sel_n = 1'b0;
      @(negedge clk);
      #1 chk("R4 after cs end", {1'b0, dq_out}, {1'b0, 8'h00});

      // R8 R9 settling window after write end (read held open)
      wr_busy = 1'b0;
      arr_rd = 8'hC3;
      #1 chk("R8 settle start", {1'b0, dq_out}, {1'b0, 8'h80});
      repeat (ST) @(negedge clk);
      #1 chk("R8 settle last", {1'b0, dq_out}, {1'b0, 8'h80});
      @(negedge clk);
      #1 chk("R9 settle over", {1'b0, dq_out}, {1'b0, 8'hC3});
      chip_sel_n = 1'b1;
      out_en_n = 1'b1;

      // R6 R4 erase
      @(negedge clk);
      er_busy = 1'b1;
      last_ld = 8'h00;
      arr_rd = 8'hFF;
      for (int i = 0; i < 4; i++) begin
         rd_access(v);
         chk("R6 R4 erase status", {1'b0, v}, {1'b0, ((i % 2) == 0) ? 8'h40 : 8'h00});
      end

      // R10 both busy: write encoding, restarted by the write start
      @(negedge clk);
      wr_busy = 1'b1;
      rd_access(v);
      chk("R10 both busy first", {1'b0, v}, {1'b0, 8'hC0});
      rd_access(v);
      chk("R10 both busy second", {1'b0, v}, {1'b0, 8'h80});
      @(negedge clk);
      wr_busy = 1'b0;
      er_busy = 1'b0;
      repeat (ST + 3) @(negedge clk);

      // R7 cycle start and read end on the same edge
      chip_sel_n = 1'b0;
      out_en_n = 1'b0;
      @(negedge clk);
      chip_sel_n = 1'b1;
      out_en_n = 1'b1;
      wr_busy = 1'b1;
      rd_access(v);
      chk("R7 start beats read end", {1'b0, v}, {1'b0, 8'hC0});
      @(negedge clk);
      wr_busy = 1'b0;
      repeat (ST + 3) @(negedge clk);

      // R1 after all traffic, strobes high
      #1 chk("R1 final idle", {dq_oe, dq_out}, {1'b0, 8'h00});

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule